// File: doc/BRIEF.md
# Table-Driven Serial Flash Sequencer

This block runs one short program of flash bus steps against a serial flash attached by one, two or four data lines. A start command picks a program by index and gives the number of data bytes for the transfer. The block then reads the program from an external instruction table, two 16-bit steps per 32-bit word. Step by step it drives chip select, the serial clock and the IO lines. Outgoing bytes come from a transmit FIFO and incoming bytes go to a receive FIFO.

A program is a list of steps. Each step sends one byte, waits a number of idle clocks, or moves the data bytes. Each step picks its own line width, so one program can send a single-line command, then a four-line address, then read on four lines. When the program ends, the block raises a sticky done flag. That flag can drive an interrupt.

Top module: `flash_seq`

## Requirements
- R1: A step is 16 bits: opcode in [15:10], line code in [9:8], operand in [7:0]. Program `s`, step `k` (0..7) is read from table word `s*4 + k/2`. Even steps sit in bits [15:0] and odd steps in [31:16]. Steps run in increasing `k`.
- R2: Opcode 1 (command) and opcode 4 (mode) send the operand byte most significant bit first. Line code 0 sends 1 bit per clock on IO[0], code 1 sends 2 bits on IO[1:0], and codes 2 and 3 send 4 bits on IO[3:0]. IO[0] carries the lowest bit of each group. The driven lines have their output enables set. Data is stable while `sck` is high.
- R3: Opcode 3 (dummy) gives `min(operand,64)` clock pulses with no IO line driven. An operand of 0 gives no pulses.
- R4: Opcode 7 (read) receives the byte count from the start command. It samples IO at the end of each clock high phase, most significant group first, and pushes one `rx_push` per byte.
- R5: Opcode 8 (write) sends the byte count, popping one FIFO byte per byte sent. While `tx_empty` is high, the clock is held low and nothing is sent.
- R6: Opcode 0 (or any undefined opcode) ends the program. A program with no stop ends after step 7. Chip select is low only while a program runs.
- R7: `done` sets when a program completes and stays set until `done_clr`. `irq` is high exactly when `done` and `irq_en` are both high.
- R8: `start` latches the program index from `start_word[31:24]` and the byte count from `start_word[15:0]`. `busy` stays high until completion. A `start` while busy has no effect.
- R9: After reset `cs_n`=1, `sck`=0, `busy`=0, `done`=0, `irq`=0 and no IO line is driven.
- R10: A read or write step with a byte count of 0 gives no clock pulses and moves to the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command strobe |
| start_word | input | 32 | Program index [31:24], byte count [15:0] |
| tbl_addr | output | 10 | Instruction table word address |
| tbl_word | input | 32 | Instruction table word |
| tx_data | input | 8 | Head byte of transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_pop | output | 1 | Take head byte of transmit FIFO |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Received byte valid |
| done_clr | input | 1 | Clear done flag |
| irq_en | input | 1 | Interrupt enable |
| busy | output | 1 | Program running |
| done | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | IO line output values |
| io_oe | output | 4 | IO line output enables |
| io_in | input | 4 | IO line input values |

## Verification
The hardest case to reach is a write step stalled on an empty transmit FIFO. The bench starts a write program with the FIFO empty. It then confirms that chip select stays low, no clock pulse appears and busy holds for many cycles. Only then does it fill the FIFO and check the serial bytes. The run-to-step-7 case uses a program with no stop step, and the start-while-busy case issues a second command in the middle of a long dummy window.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int SEQ_W     = 8,
  parameter int CNT_W     = 16,
  parameter int MAX_DUMMY = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [31:0]        start_word,
  output logic [SEQ_W+1:0]   tbl_addr,
  input  logic [31:0]        tbl_word,
  input  logic [7:0]         tx_data,
  input  logic               tx_empty,
  output logic               tx_pop,
  output logic [7:0]         rx_data,
  output logic               rx_push,
  input  logic               done_clr,
  input  logic               irq_en,
  output logic               busy,
  output logic               done,
  output logic               irq,
  output logic               cs_n,
  output logic               sck,
  output logic [3:0]         io_out,
  output logic [3:0]         io_oe,
  input  logic [3:0]         io_in
);
  localparam int DW = $clog2(MAX_DUMMY + 1) < 4 ? 4 : $clog2(MAX_DUMMY + 1);
  localparam int LW = CNT_W;
  localparam logic [5:0] OP_CMD = 6'd1, OP_DUMMY = 6'd3, OP_MODE = 6'd4,
                         OP_READ = 6'd7, OP_WRITE = 6'd8;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_RUN, S_FIN} st_t;
  typedef enum logic [1:0] {K_OUT, K_DUM, K_RD, K_WR} kind_t;

  st_t              st;
  kind_t            kind;
  logic [SEQ_W-1:0] seq;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       step;
  logic [1:0]       pad;
  logic             ph;
  logic [7:0]       sh, nxt_sh;
  logic [LW-1:0]    left;
  logic [DW-1:0]    grp;
  logic [3:0]       bits, mask;

  wire [15:0]   ins  = step[0] ? tbl_word[31:16] : tbl_word[15:0];
  wire [5:0]    opc  = ins[15:10];
  wire [1:0]    ipad = ins[9:8];
  wire [7:0]    opr  = ins[7:0];
  wire [DW-1:0] ipb  = (ipad == 2'd0) ? DW'(8) : (ipad == 2'd1) ? DW'(4) : DW'(2);
  wire [DW-1:0] gpb  = (pad == 2'd0) ? DW'(8) : (pad == 2'd1) ? DW'(4) : DW'(2);
  wire [DW-1:0] dcnt = (32'(opr) > MAX_DUMMY) ? DW'(MAX_DUMMY) : DW'(opr);
  wire          last = (step == 3'd7);
  wire          drv  = (st == S_RUN) && (kind == K_OUT || kind == K_WR);

  always_comb begin
    case (pad)
      2'd0:    begin nxt_sh = {sh[6:0], io_in[0]};   bits = {3'b0, sh[7]};   mask = 4'h1; end
      2'd1:    begin nxt_sh = {sh[5:0], io_in[1:0]}; bits = {2'b0, sh[7:6]}; mask = 4'h3; end
      default: begin nxt_sh = {sh[3:0], io_in};      bits = sh[7:4];         mask = 4'hF; end
    endcase
  end

  assign tbl_addr = {seq, step[2:1]};
  assign busy     = (st != S_IDLE);
  assign cs_n     = (st == S_IDLE);
  assign sck      = (st == S_RUN) && ph;
  assign io_out   = drv ? bits : 4'h0;
  assign io_oe    = drv ? mask : 4'h0;
  assign tx_pop   = (st == S_LOAD) && !tx_empty;
  assign irq      = done & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_OUT; seq <= '0; cnt <= '0; step <= '0; pad <= '0;
      ph <= 1'b0; sh <= '0; left <= '0; grp <= '0; rx_data <= '0; rx_push <= 1'b0;
      done <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (st == S_FIN) done <= 1'b1;
      else if (done_clr) done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          seq  <= start_word[31 -: SEQ_W];
          cnt  <= start_word[CNT_W-1:0];
          step <= '0;
          st   <= S_FETCH;
        end
        S_FETCH: begin
          pad <= ipad;
          ph  <= 1'b0;
          case (opc)
            OP_CMD, OP_MODE: begin
              sh <= opr; kind <= K_OUT; left <= LW'(1); grp <= ipb; st <= S_RUN;
            end
            OP_DUMMY:
              if (opr == 8'd0) begin st <= last ? S_FIN : S_FETCH; step <= step + 3'd1; end
              else begin kind <= K_DUM; left <= LW'(1); grp <= dcnt; st <= S_RUN; end
            OP_READ:
              if (cnt == '0) begin st <= last ? S_FIN : S_FETCH; step <= step + 3'd1; end
              else begin kind <= K_RD; left <= LW'(cnt); grp <= ipb; st <= S_RUN; end
            OP_WRITE:
              if (cnt == '0) begin st <= last ? S_FIN : S_FETCH; step <= step + 3'd1; end
              else begin kind <= K_WR; left <= LW'(cnt); st <= S_LOAD; end
            default: st <= S_FIN;
          endcase
        end
        S_LOAD: if (!tx_empty) begin
          sh <= tx_data; grp <= gpb; ph <= 1'b0; st <= S_RUN;
        end
        S_RUN:
          if (!ph) ph <= 1'b1;
          else begin
            ph <= 1'b0;
            if (kind != K_DUM) sh <= nxt_sh;
            if (grp != DW'(1)) grp <= grp - DW'(1);
            else begin
              if (kind == K_RD) begin rx_data <= nxt_sh; rx_push <= 1'b1; end
              if (left != LW'(1)) begin
                left <= left - LW'(1);
                if (kind == K_WR) st <= S_LOAD;
                else grp <= gpb;
              end else begin
                st <= last ? S_FIN : S_FETCH;
                step <= step + 3'd1;
              end
            end
          end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       busy,
  input logic       done,
  input logic       tx_pop,
  input logic       tx_empty,
  input logic       rx_push
);
  a_r6_sck_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  a_r2_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(io_out));
  a_r7_done_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $rose(cs_n));
  a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r5_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  a_r4_read_not_driving: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (io_oe == 4'h0));
  a_r6_select_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

bind flash_seq flash_seq_chk u_chk (.*);

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, done_clr = 1'b0, irq_en = 1'b0;
  logic [31:0] start_word = '0;
  logic [9:0]  tbl_addr;
  logic [31:0] tbl_word;
  logic [7:0]  tx_data, rx_data;
  logic        tx_empty, tx_pop, rx_push, busy, done, irq, cs_n, sck;
  logic [3:0]  io_out, io_oe, io_in = 4'h0;

  logic [31:0] tbl [0:1023];
  logic [7:0]  txq [0:15];
  logic [3:0]  tx_rd = '0, tx_wr = '0;
  logic [7:0]  rxb [0:15];
  int          rxn = 0, pulses = 0, nchk = 0, nerr = 0;
  logic [63:0] cap = '0;
  logic [31:0] rd_src = '0;
  logic [3:0]  oe_seen = '0;
  int          bw = 1;

  localparam logic [15:0] VEC [6] = '{16'h04A7, 16'h105C, 16'h053E, 16'h11C1, 16'h069B, 16'h1264};

  always #2 clk = ~clk;

  assign tbl_word = tbl[tbl_addr];
  assign tx_data  = txq[tx_rd];
  assign tx_empty = (tx_rd == tx_wr);

  flash_seq u0 (.*);

  always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 4'd1;
  always @(negedge clk) if (rx_push) begin rxb[rxn] = rx_data; rxn++; end

  always @(posedge sck) begin
    pulses++;
    cap = (cap << bw) | 64'(io_out & ((4'h1 << bw) - 4'h1));
    oe_seen = oe_seen | io_oe;
    io_in = 4'(rd_src >> (32 - bw));
    rd_src = rd_src << bw;
  end

  function automatic logic [15:0] mk(input logic [5:0] op, input logic [1:0] p, input logic [7:0] v);
    return {op, p, v};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] w);
    @(negedge clk);
    pulses = 0; cap = '0; oe_seen = '0; rxn = 0;
    done_clr = 1'b1; start_word = w; start = 1'b1;
    @(negedge clk);
    done_clr = 1'b0; start = 1'b0;
  endtask

  task automatic finish_wait;
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk("R8 completion timeout", 1, 0);
    @(negedge clk);
  endtask

  initial begin
    #600000;
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) tbl[i] = '0;
    for (int i = 0; i < 16; i++) txq[i] = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset cs_n/sck/busy/done/irq/oe", {cs_n, sck, busy, done, irq, io_oe},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      tbl[0] = {16'h0000, VEC[i]};
      bw = 1 << VEC[i][9:8];
      launch(32'h0);
      finish_wait();
      chk("R2 shifted byte", cap[7:0], VEC[i][7:0]);
      chk("R2 clock count", pulses, 8 / bw);
      chk("R2 output enables", oe_seen, (bw == 1) ? 4'h1 : (bw == 2) ? 4'h3 : 4'hF);
      chk("R6 deselected after stop", cs_n, 1'b1);
    end

    tbl[4] = {mk(6'd4, 2'd0, 8'h12), mk(6'd1, 2'd0, 8'h0B)};
    tbl[5] = {16'h0000, mk(6'd4, 2'd0, 8'h34)};
    bw = 1;
    launch({8'd1, 24'd0});
    finish_wait();
    chk("R1 step order across words", cap[23:0], 24'h0B1234);
    chk("R1 clock count", pulses, 24);

    for (int k = 0; k < 4; k++)
      tbl[8 + k] = {mk(6'd1, 2'd2, 8'(8'h11 + 2 * k)), mk(6'd1, 2'd2, 8'(8'h10 + 2 * k))};
    tbl[12] = {mk(6'd1, 2'd2, 8'hEE), mk(6'd1, 2'd2, 8'hEE)};
    bw = 4;
    launch({8'd2, 24'd0});
    finish_wait();
    chk("R6 ends after step 7", cap, 64'h1011121314151617);
    chk("R6 pulses for eight steps", pulses, 16);

    bw = 1;
    tbl[12] = {16'h0000, mk(6'd3, 2'd0, 8'd10)};
    launch({8'd3, 24'd0});
    finish_wait();
    chk("R3 dummy pulses", pulses, 10);
    chk("R3 dummy drives no line", oe_seen, 4'h0);
    tbl[12] = {16'h0000, mk(6'd3, 2'd0, 8'd0)};
    launch({8'd3, 24'd0});
    finish_wait();
    chk("R3 zero dummy", pulses, 0);

    tbl[12] = {16'h0000, mk(6'd3, 2'd0, 8'd200)};
    launch({8'd3, 24'd0});
    repeat (10) @(negedge clk);
    start_word = {8'd1, 24'd0}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_wait();
    chk("R3 dummy clamped to 64", pulses, 64);
    repeat (10) @(negedge clk);
    chk("R8 start while busy ignored", {busy, 32'(pulses)}, {1'b0, 32'd64});

    tbl[16] = {16'h0000, mk(6'd7, 2'd2, 8'h00)};
    bw = 4; rd_src = 32'hC35A96E1;
    launch({8'd4, 24'd3});
    finish_wait();
    chk("R4 quad read count", rxn, 3);
    chk("R4 quad read bytes", {rxb[0], rxb[1], rxb[2]}, 24'hC35A96);
    tbl[24] = {16'h0000, mk(6'd7, 2'd1, 8'h00)};
    bw = 2; rd_src = 32'h6C9D0000;
    launch({8'd6, 24'd2});
    finish_wait();
    chk("R4 dual read bytes", {rxn[7:0], rxb[0], rxb[1]}, 24'h026C9D);
    rd_src = '0;

    bw = 4;
    launch({8'd4, 24'd0});
    finish_wait();
    chk("R10 zero count read", {32'(pulses), 32'(rxn), 31'd0, done}, {32'd0, 32'd0, 32'd1});

    tbl[20] = {16'h0000, mk(6'd8, 2'd0, 8'h00)};
    bw = 1;
    launch({8'd5, 24'd2});
    repeat (20) @(negedge clk);
    chk("R5 stall on empty FIFO", {busy, cs_n, 32'(pulses)}, {1'b1, 1'b0, 32'd0});
    txq[tx_wr] = 8'hA5; txq[tx_wr + 4'd1] = 8'h3C; tx_wr = tx_wr + 4'd2;
    finish_wait();
    chk("R5 written bytes", cap[15:0], 16'hA53C);
    chk("R5 FIFO drained", {tx_empty, 32'(pulses)}, {1'b1, 32'd16});

    irq_en = 1'b0;
    @(negedge clk);
    chk("R7 done without irq", {done, irq}, 2'b10);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R7 irq when enabled", irq, 1'b1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    @(negedge clk);
    chk("R7 done cleared", {done, irq}, 2'b00);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule